// File: doc/BRIEF.md
# Serial Transmitter with Line Break Control

This block turns bytes into asynchronous serial frames on one output line. Bytes enter an eight-entry queue. A shift stage takes bytes from the queue and sends each as a start bit, eight data bits and a stop bit. Every bit lasts sixteen pulses of an external oversampling tick. Single-cycle command strobes turn the transmitter on and off, return it to its reset state, and start or end a break. A break holds the line low (spacing).

The transmitter never cuts short a queued byte or a byte in flight. After a disable command the status flags drop at once, but the line goes idle only once every queued byte has been sent. A break request also waits until the queue and the shift stage are empty. Bytes written after the request delay it further. When the break ends, the line stays high for at least one full bit time before the next frame starts.

Top module: `uart_tx_break`

## Requirements
- R1: After hardware reset the line is high (marking), `txRdy` is 0 and `txEmt` is 0.
- R2: A frame is a low start bit, then eight data bits least significant bit first, then a high stop bit. Each bit lasts exactly 16 ticks. Queued bytes go out back to back, so eight queued bytes take 1280 ticks from the first start edge until `txEmt` rises.
- R3: The queue holds 8 bytes. A write is stored only while the transmitter is enabled and the queue is not full. Any other write is discarded, and no frame is ever sent for it.
- R4: `txEmt` is 1 exactly when the transmitter is enabled and both the queue and the shift stage are empty. `txRdy` is 1 exactly when the transmitter is enabled and the queue is not full.
- R5: An enable command makes `txRdy` and `txEmt` read 1 on the next cycle when the transmitter is idle.
- R6: A disable command makes `txRdy` and `txEmt` read 0 on the next cycle. Bytes already queued or in flight are still sent completely.
- R7: A start-break command is ignored while the transmitter is disabled. The line stays high.
- R8: A start-break command takes effect only after every byte queued before it or written while it waits has been sent. When the transmitter is already empty, the line goes low within two bit times. While the break is held, newly written bytes stay queued and the line stays low.
- R9: A stop-break command returns the line high on the next cycle. The line stays high for at least 16 ticks before the next start bit. A stop-break command given while a break is still waiting cancels it.
- R10: A reset command returns the transmitter to its hardware-reset state and drops every queued byte. It takes priority over every other command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling pulse, 16 per bit time |
| cmdEnable | input | 1 | Enable strobe |
| cmdDisable | input | 1 | Disable strobe (takes priority over enable) |
| cmdReset | input | 1 | Transmitter reset strobe |
| cmdBreakOn | input | 1 | Start-break strobe |
| cmdBreakOff | input | 1 | Stop-break strobe |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte to queue |
| txOut | output | 1 | Serial line, idle high |
| txRdy | output | 1 | Queue can accept a byte |
| txEmt | output | 1 | Queue and shift stage both empty |

## Verification
The hardest cases depend on queue occupancy at the moment a command lands: a full queue, a break request with bytes still queued, and bytes written while a break is held. The bench controls this by gating the oversampling tick. With the tick held low nothing drains, so the queue can be filled to the brim, or loaded before a disable or reset, in a known state. The tick is then released, and a bench-side decoder samples every bit at mid-bit. It also measures the gap after a break and the total time for a full queue.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic flush;     // drop queue and shift stage
    logic wrAccept;  // store the incoming byte
    logic startOk;   // a new frame may begin
    logic forceLow;  // hold the line spacing
  } txStrobes_t;
endpackage

// File: rtl/tx_control.sv
module tx_control
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       cmdEnable,
  input  logic       cmdDisable,
  input  logic       cmdReset,
  input  logic       cmdBreakOn,
  input  logic       cmdBreakOff,
  input  logic       wrEn,
  input  logic       fifoEmpty,
  input  logic       fifoFull,
  input  logic       busy,
  output logic       enabled,
  output txStrobes_t strobes
);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic          brkPend;
  logic          brkOn;
  logic          gapOn;
  logic [TW-1:0] gapCnt;
  logic          wrAccept;

  assign wrAccept = wrEn & enabled & ~fifoFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled <= 1'b0;
      brkPend <= 1'b0;
      brkOn   <= 1'b0;
      gapOn   <= 1'b0;
      gapCnt  <= '0;
    end else if (cmdReset) begin
      enabled <= 1'b0;
      brkPend <= 1'b0;
      brkOn   <= 1'b0;
      gapOn   <= 1'b0;
      gapCnt  <= '0;
    end else begin
      if (cmdDisable)      enabled <= 1'b0;
      else if (cmdEnable)  enabled <= 1'b1;

      if (cmdBreakOff) begin
        brkPend <= 1'b0;
        if (brkOn) begin
          brkOn  <= 1'b0;
          gapOn  <= 1'b1;
          gapCnt <= '0;
        end
      end else if (brkPend && fifoEmpty && !busy && !wrAccept) begin
        brkOn   <= 1'b1;
        brkPend <= 1'b0;
      end else if (cmdBreakOn && enabled && !brkOn) begin
        brkPend <= 1'b1;
      end

      if (gapOn && tick) begin
        if (gapCnt == TW'(TICKS_PER_BIT - 1)) gapOn  <= 1'b0;
        else                                   gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.flush    = cmdReset;
    strobes.wrAccept = wrAccept & ~cmdReset;
    strobes.startOk  = ~brkOn & ~gapOn;
    strobes.forceLow = brkOn;
  end
endmodule

// File: rtl/tx_datapath.sv
module tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DEPTH         = 8,
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  txStrobes_t         strobes,
  input  logic [DATA_W-1:0]  wrData,
  output logic               fifoEmpty,
  output logic               fifoFull,
  output logic               busy,
  output logic [$clog2(DEPTH+1)-1:0] fifoCnt,
  output logic               txOut
);
  localparam int FRAME = DATA_W + 2;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int BW    = $clog2(FRAME);
  localparam int TW    = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [FRAME-1:0]  frame;
  logic [TW-1:0]     tickCnt;
  logic [BW-1:0]     bitCnt;
  logic              lastTick, load, push;

  assign fifoEmpty = (fifoCnt == '0);
  assign fifoFull  = (fifoCnt == CW'(DEPTH));
  assign push      = strobes.wrAccept;
  assign lastTick  = busy & tick & (tickCnt == TW'(TICKS_PER_BIT - 1))
                   & (bitCnt == BW'(FRAME - 1));
  assign load      = strobes.startOk & tick & ~fifoEmpty & (~busy | lastTick);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else if (strobes.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (load) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, load})
        2'b10:   fifoCnt <= fifoCnt + 1'b1;
        2'b01:   fifoCnt <= fifoCnt - 1'b1;
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      frame   <= '1;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (strobes.flush) begin
      busy    <= 1'b0;
      frame   <= '1;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      frame   <= {1'b1, mem[rdPtr], 1'b0};
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (busy && tick) begin
      if (tickCnt == TW'(TICKS_PER_BIT - 1)) begin
        tickCnt <= '0;
        frame   <= {1'b1, frame[FRAME-1:1]};
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == BW'(FRAME - 1)) busy <= 1'b0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign txOut = strobes.forceLow ? 1'b0 : (busy ? frame[0] : 1'b1);
endmodule

// File: rtl/uart_tx_break.sv
module uart_tx_break
  import uart_tx_pkg::*;
#(
  parameter int DEPTH         = 8,
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              cmdReset,
  input  logic              cmdBreakOn,
  input  logic              cmdBreakOff,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              txOut,
  output logic              txRdy,
  output logic              txEmt
);
  localparam int CW = $clog2(DEPTH + 1);

  txStrobes_t    strobes;
  logic          enabled, fifoEmpty, fifoFull, busy;
  logic [CW-1:0] fifoCnt;

  tx_control #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick16),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .cmdBreakOn(cmdBreakOn), .cmdBreakOff(cmdBreakOff), .wrEn(wrEn),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .busy(busy),
    .enabled(enabled), .strobes(strobes)
  );

  tx_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick16), .strobes(strobes), .wrData(wrData),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .busy(busy),
    .fifoCnt(fifoCnt), .txOut(txOut)
  );

  assign txRdy = enabled & ~fifoFull;
  assign txEmt = enabled & fifoEmpty & ~busy;
endmodule

// File: rtl/uart_tx_break_chk.sv
module uart_tx_break_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       cmdEnable,
  input logic                       cmdDisable,
  input logic                       cmdReset,
  input logic                       cmdBreakOff,
  input logic                       wrEn,
  input logic                       txOut,
  input logic                       txRdy,
  input logic                       txEmt,
  input logic [$clog2(DEPTH+1)-1:0] fifoCnt
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoCnt <= CW'(DEPTH));

  a_r3_discard: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !txRdy && !cmdReset) |=> fifoCnt <= $past(fifoCnt));

  a_r4_emt_empty: assert property (@(posedge clk) disable iff (!rstN)
    txEmt |-> fifoCnt == '0);

  a_r5_enable_ready: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && !cmdDisable && !cmdReset && !wrEn && fifoCnt < CW'(DEPTH)) |=> txRdy);

  a_r6_disable_flags: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDisable && !cmdReset) |=> (!txRdy && !txEmt));

  a_r9_break_release: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBreakOff && !cmdReset && !txOut && txEmt) |=> txOut);

  a_r10_reset_cmd: assert property (@(posedge clk) disable iff (!rstN)
    cmdReset |=> (txOut && !txRdy && !txEmt && fifoCnt == '0));
endmodule

bind uart_tx_break uart_tx_break_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
  .cmdReset(cmdReset), .cmdBreakOff(cmdBreakOff), .wrEn(wrEn),
  .txOut(txOut), .txRdy(txRdy), .txEmt(txEmt), .fifoCnt(fifoCnt)
);

// File: tb/test_uart_tx_break.sv
module test_uart_tx_break;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic cmdEnable = 0, cmdDisable = 0, cmdReset = 0, cmdBreakOn = 0, cmdBreakOff = 0;
  logic wrEn = 0;
  logic [7:0] wrData = 8'h00;
  logic txOut, txRdy, txEmt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tickMode = 0;          // 0 off, 1 every cycle, 2 random
  logic lastTick = 1'b0;
  logic [7:0] expQ [$];
  int rxGot = 0;
  bit decOn = 0;
  int decSt = 0, decCnt = 0;
  logic [9:0] decBits;

  always #10 clk = ~clk;     // 50 MHz

  uart_tx_break i_uart_tx_break (
    .clk(clk), .rstN(rstN), .tick16(tick16),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .cmdBreakOn(cmdBreakOn), .cmdBreakOff(cmdBreakOff),
    .wrEn(wrEn), .wrData(wrData),
    .txOut(txOut), .txRdy(txRdy), .txEmt(txEmt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bitsToByte(input logic [9:0] b);
    return b[8:1];
  endfunction

  always @(posedge clk) lastTick <= tick16;

  always @(negedge clk) begin
    cycles++;
    case (tickMode)
      1:       tick16 = 1'b1;
      2:       tick16 = ($urandom % 3) == 0;
      default: tick16 = 1'b0;
    endcase
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // bench receiver: mid-bit sampling on tick count (R2)
  always @(negedge clk) begin
    if (!decOn) decSt = 0;
    else if (decSt == 0) begin
      if (txOut == 1'b0) begin decSt = 1; decCnt = 0; end
    end else if (lastTick) begin
      decCnt++;
      if (decCnt % 16 == 8) begin
        decBits[decCnt / 16] = txOut;
        if (decCnt / 16 == 9) begin
          decSt = 0;
          rxGot++;
          check(decBits[0] == 1'b0 && decBits[9] == 1'b1, "R2 framing",
                {decBits[9], decBits[0]}, 2);
          if (expQ.size() == 0)
            check(0, "R3 unexpected frame", bitsToByte(decBits), -1);
          else begin
            logic [7:0] e;
            e = expQ.pop_front();
            check(bitsToByte(decBits) == e, "R2 data", bitsToByte(decBits), e);
          end
        end
      end
    end
  end

  task automatic doCmd(input int which);
    case (which)
      0: cmdEnable = 1;
      1: cmdDisable = 1;
      2: cmdReset = 1;
      3: cmdBreakOn = 1;
      default: cmdBreakOff = 1;
    endcase
    @(negedge clk);
    cmdEnable = 0; cmdDisable = 0; cmdReset = 0; cmdBreakOn = 0; cmdBreakOff = 0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    bit acc;
    acc = txRdy;
    wrEn = 1; wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (acc) expQ.push_back(d);
  endtask

  task automatic waitDrain(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (expQ.size() == 0 && decSt == 0 && txEmt) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int n0, t;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(txOut == 1 && txRdy == 0 && txEmt == 0, "R1 reset state",
          {txOut, txRdy, txEmt}, 3'b100);
    rstN = 1;
    @(negedge clk);

    // R5 enable while idle
    doCmd(0);
    check(txRdy == 1 && txEmt == 1, "R5 enable flags", {txRdy, txEmt}, 3);
    decOn = 1;

    // R3 fill with tick stopped, overflow discarded; R2 back-to-back timing
    for (int i = 0; i < 10; i++) writeByte(8'h10 + 8'(i));
    check(expQ.size() == 8, "R3 queue depth", expQ.size(), 8);
    check(txRdy == 0, "R3 full flag", txRdy, 0);
    check(txEmt == 0, "R4 empty flag with data", txEmt, 0);
    tickMode = 1;
    t = 0;
    while (txOut == 1 && t < 100) begin @(negedge clk); t++; end
    t = 0;
    while (!txEmt && t < 3000) begin @(negedge clk); t++; end
    check(t == 1280, "R2 eight frames duration", t, 1280);
    waitDrain(500);
    check(rxGot == 8 && expQ.size() == 0, "R3 only stored bytes sent", rxGot, 8);

    // R6 disable drains pending bytes
    tickMode = 0;
    for (int i = 0; i < 3; i++) writeByte(8'hA0 + 8'(i));
    doCmd(1);
    check(txRdy == 0 && txEmt == 0, "R6 disable flags", {txRdy, txEmt}, 0);
    writeByte(8'hEE);        // discarded while disabled (R3)
    n0 = rxGot;
    tickMode = 1;
    for (int i = 0; i < 1000 && expQ.size() != 0; i++) @(negedge clk);
    repeat (200) @(negedge clk);
    check(rxGot - n0 == 3, "R6 pending bytes sent", rxGot - n0, 3);
    check(txOut == 1, "R6 idle line after drain", txOut, 1);
    check(txEmt == 0, "R4 disabled empty flag", txEmt, 0);

    // R7 break ignored while disabled
    doCmd(3);
    repeat (60) @(negedge clk);
    check(txOut == 1, "R7 break ignored disabled", txOut, 1);
    doCmd(0);
    check(txRdy == 1 && txEmt == 1, "R5 enable when idle", {txRdy, txEmt}, 3);
    repeat (60) @(negedge clk);
    check(txOut == 1, "R7 no latent break", txOut, 1);

    // R8 break from empty
    doCmd(3);
    repeat (2) @(negedge clk);
    check(txOut == 0, "R8 break from empty", txOut, 0);
    decOn = 0;
    doCmd(4);
    check(txOut == 1, "R9 release line", txOut, 1);
    repeat (40) @(negedge clk);
    decOn = 1;

    // R8 break waits for pending bytes and bytes written while waiting
    writeByte(8'hA5);
    doCmd(3);
    writeByte(8'h3C);
    n0 = rxGot;
    for (int i = 0; i < 1000 && rxGot - n0 < 2; i++) @(negedge clk);
    decOn = 0;
    check(rxGot - n0 == 2, "R8 bytes before break", rxGot - n0, 2);
    repeat (20) @(negedge clk);
    check(txOut == 0 && txEmt == 1, "R8 break after drain", {txOut, txEmt}, 1);
    writeByte(8'h81);
    repeat (100) @(negedge clk);
    check(txOut == 0 && txEmt == 0, "R8 held byte during break", {txOut, txEmt}, 0);
    doCmd(4);
    check(txOut == 1, "R9 line high after stop", txOut, 1);
    decOn = 1;
    t = 0;
    while (txOut == 1 && t < 300) begin @(negedge clk); t++; end
    check(t >= 16 && t < 300, "R9 marking gap", t, 16);
    waitDrain(1000);
    check(expQ.size() == 0, "R9 held byte sent", expQ.size(), 0);

    // R10 reset command flushes
    tickMode = 0;
    for (int i = 0; i < 4; i++) writeByte(8'h55);
    doCmd(2);
    check(txOut == 1 && txRdy == 0 && txEmt == 0, "R10 reset state",
          {txOut, txRdy, txEmt}, 3'b100);
    expQ.delete();
    n0 = rxGot;
    doCmd(0);
    tickMode = 1;
    repeat (400) @(negedge clk);
    check(rxGot == n0 && txEmt == 1, "R10 queue flushed", rxGot - n0, 0);

    // random traffic with random tick spacing (R2, R3, R4)
    tickMode = 2;
    n0 = rxGot;
    for (int k = 0; k < 40; ) begin
      if ($urandom % 4 == 0) begin
        if (txRdy) k++;
        writeByte(8'($urandom));
      end else @(negedge clk);
    end
    waitDrain(60000);
    check(expQ.size() == 0 && txEmt == 1, "R4 random drain", expQ.size(), 0);
    check(rxGot - n0 == 40, "R3 random count", rxGot - n0, 40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule